// File: doc/BRIEF.md
# Multi-Mode Counter Timer

This block is a 16-bit down counter driven by a clock enable. The enable comes from a source that software selects: the system clock, divided or not, an external pin, the 1x transmit clocks of two serial channels, or the load strobes of two receive FIFOs. When the counter counts those strobes it becomes a counter of received characters. The preset is written one byte at a time. A start command loads the preset into the counter, and a stop command freezes the counter so that a byte-wise read always sees a settled value.

There are three operating modes. Single-shot count mode counts down once and marks reaching zero with a one-cycle pulse. Square-wave timer mode reloads the counter and toggles its output every time it expires. Pulse timer mode reloads the same way but emits a narrow pulse, which gives twice the square-wave rate. Until the block's own configuration register is first written, the mode and the source follow a legacy configuration input.

Top module: `mmct_top`

## Requirements
- R1: After synchronous reset the count reads 0, `ct_out` is low, the preset is 0, the counter is stopped and the configuration follows `legacy_mode`/`legacy_src`.
- R2: The first `cfg_we` pulse hands control of mode and source to the written register, and from then on `legacy_mode`/`legacy_src` have no effect.
- R3: `preset_hi_we`/`preset_lo_we` store `preset_byte` as bits 15:8 / 7:0 of the preset. `start` copies the preset into the count on the next edge and sets the counter running. `rd_byte` shows count bits 15:8 when `rd_upper`=1 and bits 7:0 when it is 0.
- R4: Mode 00 (count): each tick decrements the count. The tick that takes the count from 1 to 0 stops the counter and raises `ct_out` for exactly one clock. A preset of 0 behaves as 65536.
- R5: Mode 01 (square): on the tick that finds a count of 1 the preset reloads and `ct_out` toggles, which gives a period of 2×preset ticks. Every other tick decrements the count.
- R6: Mode 11 (pulse): the reload happens as in R5, but `ct_out` goes high at the reload and falls at the next tick, giving one pulse every preset ticks.
- R7: `stop` freezes the count. While the counter is stopped the count does not change until the next `start`.
- R8: Source codes 0010, 0011, 0100, 0101, 0110 and 0111 tick once every 1, 2, 16, 32, 64 and 128 clocks, taken from a free-running prescaler.
- R9: Source 0000 ticks on each synchronized rising edge of `ext_pin`. Source 0001 ticks on every 16th such edge.
- R10: Sources 1000, 1001, 1100 and 1101 tick on `tx1x_a`, `tx1x_b`, `rx_load_a` and `rx_load_b` strobes respectively. Strobes on the unselected inputs do not change the count.
- R11: Source codes 1010, 1011, 1110 and 1111 never tick. Mode 10 leaves the count at the preset and `ct_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write mode/source register |
| cfg_mode | input | 2 | Mode written by cfg_we |
| cfg_src | input | 4 | Source written by cfg_we |
| legacy_mode | input | 2 | Mode used before the first cfg_we |
| legacy_src | input | 4 | Source used before the first cfg_we |
| preset_hi_we | input | 1 | Write preset upper byte |
| preset_lo_we | input | 1 | Write preset lower byte |
| preset_byte | input | 8 | Preset byte data |
| start | input | 1 | Load preset and run |
| stop | input | 1 | Freeze count |
| ext_pin | input | 1 | Asynchronous external clock pin |
| tx1x_a | input | 1 | Channel A transmit 1x strobe |
| tx1x_b | input | 1 | Channel B transmit 1x strobe |
| rx_load_a | input | 1 | Channel A receive FIFO load strobe |
| rx_load_b | input | 1 | Channel B receive FIFO load strobe |
| rd_upper | input | 1 | Select upper count byte for rd_byte |
| rd_byte | output | 8 | Selected count byte |
| ct_out | output | 1 | Mode-dependent timer output |

## Verification
The assertions assume that the mode and the source stay fixed while the counter is running, that `start` and `stop` are never raised together, and that the strobe inputs are single-cycle pulses synchronous to `clk`. The stimulus always issues a stop before it rewrites the configuration. It separates commands by at least one idle clock and holds each strobe for one clock only. It drives `ext_pin` in pulses at least two clocks wide, so that the synchronizer sees every edge.

// File: rtl/mmct_pkg.sv
package mmct_pkg;

    typedef enum logic [1:0] {
        MODE_COUNT  = 2'b00,
        MODE_SQUARE = 2'b01,
        MODE_RSVD   = 2'b10,
        MODE_PULSE  = 2'b11
    } ct_mode_e;

    typedef enum logic [3:0] {
        SRC_PIN    = 4'b0000,
        SRC_PIN16  = 4'b0001,
        SRC_DIV1   = 4'b0010,
        SRC_DIV2   = 4'b0011,
        SRC_DIV16  = 4'b0100,
        SRC_DIV32  = 4'b0101,
        SRC_DIV64  = 4'b0110,
        SRC_DIV128 = 4'b0111,
        SRC_TXA    = 4'b1000,
        SRC_TXB    = 4'b1001,
        SRC_RSV_A  = 4'b1010,
        SRC_RSV_B  = 4'b1011,
        SRC_RXA    = 4'b1100,
        SRC_RXB    = 4'b1101,
        SRC_RSV_E  = 4'b1110,
        SRC_RSV_F  = 4'b1111
    } ct_src_e;

    typedef struct packed {
        ct_mode_e mode;
        ct_src_e  src;
    } ct_cfg_t;

    // Low-bit mask of the prescaler that must be all ones for a divided tick.
    function automatic logic [6:0] div_mask(ct_src_e s);
        case (s)
            SRC_DIV2:   return 7'h01;
            SRC_DIV16:  return 7'h0F;
            SRC_DIV32:  return 7'h1F;
            SRC_DIV64:  return 7'h3F;
            SRC_DIV128: return 7'h7F;
            default:    return 7'h00;
        endcase
    endfunction

    function automatic logic src_reserved(ct_src_e s);
        return (s == SRC_RSV_A) || (s == SRC_RSV_B) ||
               (s == SRC_RSV_E) || (s == SRC_RSV_F);
    endfunction

endpackage

// File: rtl/mmct_tick_gen.sv
module mmct_tick_gen
    import mmct_pkg::*;
#(
    parameter int PRE_W       = 7,
    parameter int EXT_DIV_W   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  ct_src_e src,
    input  logic    ext_pin,
    input  logic    tx_a,
    input  logic    tx_b,
    input  logic    rx_a,
    input  logic    rx_b,
    output logic    tick
);
    localparam int SYNC_LEN = SYNC_STAGES + 1;

    logic [PRE_W-1:0]     pre_q;
    logic [SYNC_LEN-1:0]  sync_q;
    logic [EXT_DIV_W-1:0] ext_div_q;
    logic                 pin_edge;
    logic                 pin_div_tick;
    logic [PRE_W-1:0]     mask;
    logic                 div_tick;

    // Free-running prescaler shared by all divided sources.
    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    // Synchronizer chain for the external pin plus one stage for edge detect.
    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ext_pin;
    end

    for (genvar g = 1; g < SYNC_LEN; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b0;
            else     sync_q[g] <= sync_q[g-1];
        end
    end

    assign pin_edge = sync_q[SYNC_LEN-2] & ~sync_q[SYNC_LEN-1];

    always_ff @(posedge clk) begin
        if (rst)           ext_div_q <= '0;
        else if (pin_edge) ext_div_q <= ext_div_q + 1'b1;
    end

    assign pin_div_tick = pin_edge & (&ext_div_q);
    assign mask         = PRE_W'(div_mask(src));
    assign div_tick     = ((pre_q & mask) == mask);

    always_comb begin
        case (src)
            SRC_PIN:    tick = pin_edge;
            SRC_PIN16:  tick = pin_div_tick;
            SRC_DIV1, SRC_DIV2, SRC_DIV16,
            SRC_DIV32, SRC_DIV64, SRC_DIV128:
                        tick = div_tick;
            SRC_TXA:    tick = tx_a;
            SRC_TXB:    tick = tx_b;
            SRC_RXA:    tick = rx_a;
            SRC_RXB:    tick = rx_b;
            default:    tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/mmct_core.sv
module mmct_core
    import mmct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  ct_mode_e         mode,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dec;
    logic             run_q;
    logic             out_q;
    logic             expire;

    assign dec    = cnt_q - ONE;
    assign expire = (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else if (start) begin
            cnt_q <= preset;
            run_q <= 1'b1;
            out_q <= 1'b0;
        end else if (stop) begin
            run_q <= 1'b0;
            if (mode != MODE_SQUARE) out_q <= 1'b0;
        end else if (run_q && tick) begin
            case (mode)
                MODE_COUNT: begin
                    cnt_q <= dec;
                    out_q <= expire;
                    if (expire) run_q <= 1'b0;
                end
                MODE_SQUARE: begin
                    if (expire) begin
                        cnt_q <= preset;
                        out_q <= ~out_q;
                    end else begin
                        cnt_q <= dec;
                    end
                end
                MODE_PULSE: begin
                    cnt_q <= expire ? preset : dec;
                    out_q <= expire;
                end
                default: out_q <= 1'b0;
            endcase
        end else if (mode == MODE_COUNT || mode == MODE_RSVD) begin
            out_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;
    assign run = run_q;
    assign out = out_q;

endmodule

// File: rtl/mmct_top.sv
module mmct_top
    import mmct_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PRE_W       = 7,
    parameter int EXT_DIV_W   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_mode,
    input  logic [3:0]        cfg_src,
    input  logic [1:0]        legacy_mode,
    input  logic [3:0]        legacy_src,
    input  logic              preset_hi_we,
    input  logic              preset_lo_we,
    input  logic [BYTE_W-1:0] preset_byte,
    input  logic              start,
    input  logic              stop,
    input  logic              ext_pin,
    input  logic              tx1x_a,
    input  logic              tx1x_b,
    input  logic              rx_load_a,
    input  logic              rx_load_b,
    input  logic              rd_upper,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              ct_out
);
    localparam int CNT_W = 2 * BYTE_W;

    ct_cfg_t          cfg_q;
    logic             own_q;
    logic [CNT_W-1:0] preset_q;
    ct_mode_e         eff_mode;
    ct_src_e          eff_src;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: MODE_COUNT, src: SRC_PIN};
            own_q <= 1'b0;
        end else if (cfg_we) begin
            cfg_q <= '{mode: ct_mode_e'(cfg_mode), src: ct_src_e'(cfg_src)};
            own_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            preset_q <= '0;
        end else begin
            if (preset_hi_we) preset_q[CNT_W-1:BYTE_W] <= preset_byte;
            if (preset_lo_we) preset_q[BYTE_W-1:0]     <= preset_byte;
        end
    end

    assign eff_mode = own_q ? cfg_q.mode : ct_mode_e'(legacy_mode);
    assign eff_src  = own_q ? cfg_q.src  : ct_src_e'(legacy_src);

    mmct_tick_gen #(
        .PRE_W      (PRE_W),
        .EXT_DIV_W  (EXT_DIV_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .src    (eff_src),
        .ext_pin(ext_pin),
        .tx_a   (tx1x_a),
        .tx_b   (tx1x_b),
        .rx_a   (rx_load_a),
        .rx_b   (rx_load_b),
        .tick   (tick)
    );

    mmct_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (start),
        .stop  (stop),
        .mode  (eff_mode),
        .preset(preset_q),
        .cnt   (cnt),
        .run   (run),
        .out   (ct_out)
    );

    assign rd_byte = rd_upper ? cnt[CNT_W-1:BYTE_W] : cnt[BYTE_W-1:0];

endmodule

// File: rtl/mmct_checker.sv
module mmct_checker
    import mmct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stop,
    input logic             tick,
    input ct_mode_e         eff_mode,
    input ct_src_e          eff_src,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] preset_q,
    input logic             run,
    input logic             ct_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_start_load_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == $past(preset_q)) && run);

    assert_terminal_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (eff_mode == MODE_COUNT && run && tick && cnt == ONE && !start && !stop)
        |=> (!run && cnt == '0 && ct_out));

    assert_terminal_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (eff_mode == MODE_COUNT && ct_out && !start) |=> !ct_out);

    assert_square_step_R5: assert property (@(posedge clk) disable iff (rst)
        (eff_mode == MODE_SQUARE && run && tick && cnt != ONE && !start && !stop)
        |=> (cnt == $past(cnt) - ONE) && $stable(ct_out));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!run && !start) |=> $stable(cnt));

    assert_reserved_no_tick_R11: assert property (@(posedge clk) disable iff (rst)
        src_reserved(eff_src) |-> !tick);

endmodule

bind mmct_top mmct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .stop    (stop),
    .tick    (tick),
    .eff_mode(eff_mode),
    .eff_src (eff_src),
    .cnt     (cnt),
    .preset_q(preset_q),
    .run     (run),
    .ct_out  (ct_out)
);

// File: tb/mmct_top_tb.sv
module mmct_top_tb;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] preset;
        logic [15:0] k;
        logic [15:0] exp_cnt;
        logic        exp_out;
    } vec_t;

    // Source is the undivided system clock for all rows; k = edges after the load edge.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 16'd5,      16'd2,      16'd3,      1'b0},  // R4
        '{2'b00, 16'd5,      16'd5,      16'd0,      1'b1},  // R4
        '{2'b00, 16'd5,      16'd8,      16'd0,      1'b0},  // R4
        '{2'b01, 16'd4,      16'd3,      16'd1,      1'b0},  // R5
        '{2'b01, 16'd4,      16'd4,      16'd4,      1'b1},  // R5
        '{2'b01, 16'd4,      16'd9,      16'd3,      1'b0},  // R5
        '{2'b11, 16'd3,      16'd3,      16'd3,      1'b1},  // R6
        '{2'b11, 16'd3,      16'd4,      16'd2,      1'b0},  // R6
        '{2'b11, 16'd3,      16'd6,      16'd3,      1'b1},  // R6
        '{2'b00, 16'h0102,   16'h0100,   16'h0002,   1'b0}   // R3
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic [3:0] cfg_src = '0;
    logic [1:0] legacy_mode = '0;
    logic [3:0] legacy_src = '0;
    logic       preset_hi_we = 1'b0;
    logic       preset_lo_we = 1'b0;
    logic [7:0] preset_byte = '0;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic       ext_pin = 1'b0;
    logic       tx1x_a = 1'b0;
    logic       tx1x_b = 1'b0;
    logic       rx_load_a = 1'b0;
    logic       rx_load_b = 1'b0;
    logic       rd_upper = 1'b0;
    logic [7:0] rd_byte;
    logic       ct_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int out_hi = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (ct_out) out_hi <= out_hi + 1;

    mmct_top u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
        .legacy_mode(legacy_mode), .legacy_src(legacy_src),
        .preset_hi_we(preset_hi_we), .preset_lo_we(preset_lo_we), .preset_byte(preset_byte),
        .start(start), .stop(stop), .ext_pin(ext_pin), .tx1x_a(tx1x_a), .tx1x_b(tx1x_b),
        .rx_load_a(rx_load_a), .rx_load_b(rx_load_b), .rd_upper(rd_upper),
        .rd_byte(rd_byte), .ct_out(ct_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read16(output logic [15:0] v);
        rd_upper = 1'b0; #1; v[7:0]  = rd_byte;
        rd_upper = 1'b1; #1; v[15:8] = rd_byte;
        rd_upper = 1'b0;
    endtask

    task automatic set_preset(logic [15:0] p);
        preset_hi_we = 1'b1; preset_byte = p[15:8]; @(negedge clk);
        preset_hi_we = 1'b0; preset_lo_we = 1'b1; preset_byte = p[7:0]; @(negedge clk);
        preset_lo_we = 1'b0;
    endtask

    task automatic set_cfg(logic [1:0] m, logic [3:0] s);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        cfg_we = 1'b1; cfg_mode = m; cfg_src = s; @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic strobe(ref logic s);
        s = 1'b1; @(negedge clk); s = 1'b0; @(negedge clk);
    endtask

    task automatic pin_pulse();
        ext_pin = 1'b1; wait_n(2); ext_pin = 1'b0; wait_n(2);
    endtask

    task automatic toggle_period(output int d);
        int t1;
        logic prev;
        t1 = 0;
        for (int h = 0; h < 2; h++) begin
            prev = ct_out;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (ct_out !== prev) break;
            end
            if (h == 0) t1 = cyc;
        end
        d = cyc - t1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        errors++;
        finish_run();
    end

    initial begin
        logic [15:0] v;
        int d;
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        read16(v);
        check("R1 count after reset", v, 16'h0000);
        check("R1 out after reset", ct_out, 1'b0);

        // R2: legacy config in control before any cfg_we (square mode, undivided clock)
        legacy_mode = 2'b01; legacy_src = 4'b0010;
        set_preset(16'd2);
        do_start(); wait_n(2);
        read16(v);
        check("R2 legacy square count", v, 16'd2);
        check("R2 legacy square out", ct_out, 1'b1);
        set_cfg(2'b00, 4'b0010);          // own config: count mode; legacy still square
        do_start(); wait_n(3);
        read16(v);
        check("R2 legacy ignored after cfg_we", v, 16'd0);

        // Vector table: mode/preset/edge-count walk
        for (int i = 0; i < NV; i++) begin
            set_cfg(VECS[i].mode, 4'b0010);
            set_preset(VECS[i].preset);
            do_start();
            wait_n(int'(VECS[i].k));
            read16(v);
            check($sformatf("R3/R4/R5/R6 row %0d count", i), v, VECS[i].exp_cnt);
            check($sformatf("R4/R5/R6 row %0d out", i), ct_out, VECS[i].exp_out);
        end

        // R4: preset 0 acts as 65536
        set_cfg(2'b00, 4'b0010);
        set_preset(16'd0);
        do_start(); wait_n(1);
        read16(v);
        check("R4 zero preset wraps", v, 16'hFFFF);

        // R7: stop freezes the count
        set_cfg(2'b01, 4'b0010);
        set_preset(16'd10);
        do_start(); wait_n(3);
        stop = 1'b1; @(negedge clk); stop = 1'b0;
        wait_n(5);
        read16(v);
        check("R7 frozen after stop", v, 16'd7);

        // R8: prescaled sources, square mode preset 2 -> toggle every 2 ticks
        set_cfg(2'b01, 4'b0100);
        set_preset(16'd2);
        do_start();
        toggle_period(d);
        check("R8 div16 half period", d, 32);
        set_cfg(2'b01, 4'b0011);
        do_start();
        toggle_period(d);
        check("R8 div2 half period", d, 4);

        // R9: external pin direct, count mode preset 3
        set_cfg(2'b00, 4'b0000);
        set_preset(16'd3);
        do_start();
        pin_pulse(); pin_pulse();
        read16(v);
        check("R9 pin edges counted", v, 16'd1);
        out_hi = 0;
        pin_pulse(); wait_n(2);
        read16(v);
        check("R9 pin terminal count", v, 16'd0);
        check("R4 terminal pulse one clock", out_hi, 1);

        // R9: external pin /16, preset 2
        set_cfg(2'b00, 4'b0001);
        set_preset(16'd2);
        do_start();
        for (int i = 0; i < 16; i++) pin_pulse();
        read16(v);
        check("R9 pin/16 after 16 edges", v, 16'd1);
        for (int i = 0; i < 16; i++) pin_pulse();
        read16(v);
        check("R9 pin/16 after 32 edges", v, 16'd0);

        // R10: receive-load A source; other strobes ignored
        set_cfg(2'b00, 4'b1100);
        set_preset(16'd4);
        do_start();
        for (int i = 0; i < 3; i++) strobe(rx_load_a);
        strobe(rx_load_b); strobe(tx1x_a); strobe(tx1x_b);
        read16(v);
        check("R10 rx A strobes counted only", v, 16'd1);

        // R10: transmit B source
        set_cfg(2'b00, 4'b1001);
        do_start();
        strobe(tx1x_b); strobe(tx1x_b);
        strobe(tx1x_a); strobe(rx_load_a); strobe(rx_load_b);
        read16(v);
        check("R10 tx B strobes counted only", v, 16'd2);

        // R11: reserved source never ticks
        set_cfg(2'b01, 4'b1010);
        set_preset(16'd6);
        do_start(); wait_n(10);
        read16(v);
        check("R11 reserved source holds", v, 16'd6);

        // R11: reserved mode holds count, output low
        set_cfg(2'b10, 4'b0010);
        set_preset(16'd7);
        do_start(); wait_n(5);
        read16(v);
        check("R11 reserved mode count", v, 16'd7);
        check("R11 reserved mode out", ct_out, 1'b0);

        finish_run();
    end

endmodule